// File: doc/BRIEF.md
# Pipelined No-Turnaround Burst SRAM

A cycle-accurate, synthesizable model of a synchronous SRAM whose read and write pipelines have the same length, so the data bus never needs an idle cycle when the traffic switches between reads and writes. Each word is 36 bits wide, made of four 9-bit lanes (8 data bits plus a parity bit). Every lane has its own active-low write strobe. The address, the lane strobes and all controls except output enable and burst order are registered on the rising clock edge. Write data is sampled two enabled edges after its address. Read data is presented two enabled edges after its address.

A command is either a load, which takes a new address, or an advance, which steps a 4-beat wrapping burst counter from the last load. An advance repeats the type of the operation that was loaded. A static select chooses linear or interleaved beat order. An active-low clock enable freezes the whole block. Output enable and sleep are combinational and gate the output drive immediately. Sleep also turns captures into deselects while it is high. The full-size part has 20 address bits. The depth is a parameter, and the default here is kept small enough for simulation.

Top module: `nbsram_top`

## Requirements
- R1: A read loaded at enabled edge k drives its word on `dout` with `dout_oe` high after enabled edge k+2, provided `oe_n` is low and `sleep` is low.
- R2: A write loaded at enabled edge k stores the `din` value that is present at enabled edge k+2, and a later read of that address returns it.
- R3: Lane i occupies bits [9i+8:9i]. It is written only when `bw_n[i]` was low at the edge that captured the write's address. Lanes whose strobe was high keep their old contents.
- R4: Reads and writes can be mixed on consecutive cycles with no idle cycle. A read loaded one cycle after a write to the same address returns the new data. A write loaded one cycle after a read of the same address does not change what that read returns.
- R5: With `order_lin`=1, advance beat n (n=1,2,3, then wrapping) uses the low offset (s+n) mod 4, where s is the two low bits of the loaded address. The upper address bits stay those of the load.
- R6: With `order_lin`=0, advance beat n uses the low offset s XOR n.
- R7: A cycle with `advance`=1 repeats the operation type of the last load, and the chip enables and `we_n` are ignored on that cycle. An advance that follows a deselected load is a deselect.
- R8: A load is a chip select only when `ce_a_n`=0, `ce_b_n`=0 and `ce_c`=1. Any other load is a deselect: it writes nothing, and `dout_oe` is low in the slot where read data would have appeared.
- R9: While `cke_n` is high, edges are ignored. Nothing is captured, no write commits, and `dout`/`dout_oe` hold their values.
- R10: `oe_n` high forces `dout_oe` low at once, without waiting for a clock edge. Whenever `dout_oe` is low, `dout` reads all zeros.
- R11: `sleep` high forces `dout_oe` low at once. A capture while `sleep` is high acts as a deselect and ends any burst. Stored words are kept.
- R12: Synchronous active-high `rst` empties the pipeline, so `dout_oe` is low after a reset edge until a new read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cke_n | input | 1 | Clock enable, active low |
| advance | input | 1 | 1 = step the burst, 0 = load a new address |
| we_n | input | 1 | Write (0) or read (1) on a load |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b_n | input | 1 | Chip enable, active low |
| ce_c | input | 1 | Chip enable, active high |
| bw_n | input | LANES | Per-lane write strobes, active low |
| order_lin | input | 1 | Static burst order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Output enable, active low, combinational |
| sleep | input | 1 | Standby, combinational output disable |
| addr | input | AW | Word address |
| din | input | LANES*LANE_W | Write data, sampled two edges after its address |
| dout | output | LANES*LANE_W | Read data, zero when not driven |
| dout_oe | output | 1 | High when `dout` drives the bus |

## Verification
The bench builds the block with AW=6, which gives 64 words, and keeps the default four 9-bit lanes. With this depth every word can be initialised before any read. Random addresses then collide often, which produces same-address write-then-read pairs and burst wraps across all four offsets. The random phase switches between linear and interleaved order. It also mixes in clock-enable stalls, partial lane masks, deselects and short sleep pulses, all checked against the bench's own memory and pipeline model.

// File: rtl/nbsram_pkg.sv
package nbsram_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Low two address bits for beat number `beat` of a burst from `start`.
    function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                               input logic [1:0] beat,
                                               input logic       linear);
        logic [1:0] sum;
        sum = start + beat;
        return linear ? sum : (start ^ beat);
    endfunction

endpackage

// File: rtl/nbsram_cmd.sv
module nbsram_cmd
    import nbsram_pkg::*;
#(
    parameter int AW    = 10,
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cke_n,
    input  logic             advance,
    input  logic             we_n,
    input  logic             ce_a_n,
    input  logic             ce_b_n,
    input  logic             ce_c,
    input  logic             sleep,
    input  logic             order_lin,
    input  logic [AW-1:0]    addr,
    input  logic [LANES-1:0] bw_n,
    output op_e              s1_op,
    output logic [AW-1:0]    s1_addr,
    output logic [LANES-1:0] s1_mask
);

    logic          selected;
    op_e           load_op;
    op_e           last_q;
    logic [AW-1:0] base_q;
    logic [1:0]    cnt_q;
    logic [1:0]    nxt_cnt;

    assign selected = !ce_a_n && !ce_b_n && ce_c;
    assign load_op  = (!selected || sleep) ? OP_IDLE
                    : (we_n ? OP_READ : OP_WRITE);
    assign nxt_cnt  = cnt_q + 2'd1;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q  <= OP_IDLE;
            s1_op   <= OP_IDLE;
            base_q  <= '0;
            cnt_q   <= '0;
            s1_addr <= '0;
            s1_mask <= '0;
        end else if (!cke_n) begin
            s1_mask <= ~bw_n;
            if (!advance) begin
                last_q  <= load_op;
                s1_op   <= load_op;
                base_q  <= addr;
                cnt_q   <= '0;
                s1_addr <= addr;
            end else begin
                cnt_q   <= nxt_cnt;
                s1_op   <= sleep ? OP_IDLE : last_q;
                if (sleep) begin
                    last_q <= OP_IDLE;
                end
                s1_addr <= {base_q[AW-1:2],
                            beat_offset(base_q[1:0], nxt_cnt, order_lin)};
            end
        end
    end

    // R8
    desel_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!cke_n && !advance && (ce_a_n || ce_b_n || !ce_c)) |=> s1_op == OP_IDLE);

    // R5
    burst_page_chk: assert property (@(posedge clk) disable iff (rst)
        (!cke_n && advance) |=> s1_addr[AW-1:2] == $past(base_q[AW-1:2]));

    // R9
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cke_n |=> ($stable(s1_addr) && $stable(s1_op) && $stable(s1_mask)));

endmodule

// File: rtl/nbsram_array.sv
module nbsram_array
    import nbsram_pkg::*;
#(
    parameter int AW     = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  op_e                     op,
    input  logic [AW-1:0]           addr,
    input  logic [LANES-1:0]        mask,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rvalid
);

    localparam int DEPTH = 1 << AW;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];
        logic [LANE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                rd_q <= '0;
            end else if (en) begin
                if (op == OP_WRITE && mask[l]) begin
                    bank[addr] <= wdata[l*LANE_W +: LANE_W];
                end
                if (op == OP_READ) begin
                    rd_q <= bank[addr];
                end
            end
        end

        assign rdata[l*LANE_W +: LANE_W] = rd_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
        end else if (en) begin
            rvalid <= (op == OP_READ);
        end
    end

    // R2
    write_slot_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (en && op == OP_WRITE) |=> !rvalid);

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(rdata) && $stable(rvalid)));

endmodule

// File: rtl/nbsram_top.sv
module nbsram_top
    import nbsram_pkg::*;
#(
    parameter int AW     = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cke_n,
    input  logic                    advance,
    input  logic                    we_n,
    input  logic                    ce_a_n,
    input  logic                    ce_b_n,
    input  logic                    ce_c,
    input  logic [LANES-1:0]        bw_n,
    input  logic                    order_lin,
    input  logic                    oe_n,
    input  logic                    sleep,
    input  logic [AW-1:0]           addr,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_oe
);

    localparam int W = LANES * LANE_W;

    op_e              s1_op;
    op_e              s2_op;
    logic [AW-1:0]    s1_addr;
    logic [AW-1:0]    s2_addr;
    logic [LANES-1:0] s1_mask;
    logic [LANES-1:0] s2_mask;
    logic [W-1:0]     rdata;
    logic             rvalid;
    logic             clk_en;

    assign clk_en = !cke_n;

    nbsram_cmd #(.AW(AW), .LANES(LANES)) u_cmd (
        .clk       (clk),
        .rst       (rst),
        .cke_n     (cke_n),
        .advance   (advance),
        .we_n      (we_n),
        .ce_a_n    (ce_a_n),
        .ce_b_n    (ce_b_n),
        .ce_c      (ce_c),
        .sleep     (sleep),
        .order_lin (order_lin),
        .addr      (addr),
        .bw_n      (bw_n),
        .s1_op     (s1_op),
        .s1_addr   (s1_addr),
        .s1_mask   (s1_mask)
    );

    // Second pipeline stage: aligns commands with the data bus slot.
    always_ff @(posedge clk) begin
        if (rst) begin
            s2_op   <= OP_IDLE;
            s2_addr <= '0;
            s2_mask <= '0;
        end else if (clk_en) begin
            s2_op   <= s1_op;
            s2_addr <= s1_addr;
            s2_mask <= s1_mask;
        end
    end

    nbsram_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk    (clk),
        .rst    (rst),
        .en     (clk_en),
        .op     (s2_op),
        .addr   (s2_addr),
        .mask   (s2_mask),
        .wdata  (din),
        .rdata  (rdata),
        .rvalid (rvalid)
    );

    assign dout_oe = rvalid && !oe_n && !sleep;
    assign dout    = dout_oe ? rdata : '0;

    // R1
    read_slot_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (clk_en && s2_op == OP_READ) |=> (dout_oe == (!oe_n && !sleep)));

    // R8
    idle_slot_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (clk_en && s2_op == OP_IDLE) |=> !dout_oe);

    // R12
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> !dout_oe);

endmodule

// File: tb/tb_nbsram_top.sv
`timescale 1ns/1ps
module tb_nbsram_top;
    import nbsram_pkg::*;

    localparam int AW     = 6;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int W      = LANES * LANE_W;
    localparam int DEPTH  = 1 << AW;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cke_n = 1'b1;
    logic             advance = 1'b0;
    logic             we_n = 1'b1;
    logic             ce_a_n = 1'b1;
    logic             ce_b_n = 1'b1;
    logic             ce_c = 1'b0;
    logic [LANES-1:0] bw_n = '1;
    logic             order_lin = 1'b1;
    logic             oe_n = 1'b0;
    logic             sleep = 1'b0;
    logic [AW-1:0]    addr = '0;
    logic [W-1:0]     din = '0;
    logic [W-1:0]     dout;
    logic             dout_oe;

    always #2.5 clk = ~clk;

    nbsram_top #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) dut (
        .clk(clk), .rst(rst), .cke_n(cke_n), .advance(advance), .we_n(we_n),
        .ce_a_n(ce_a_n), .ce_b_n(ce_b_n), .ce_c(ce_c), .bw_n(bw_n),
        .order_lin(order_lin), .oe_n(oe_n), .sleep(sleep), .addr(addr),
        .din(din), .dout(dout), .dout_oe(dout_oe)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R12";

    // Bench reference model
    logic [W-1:0]     ref_mem [DEPTH];
    op_e              m1_op = OP_IDLE, m2_op = OP_IDLE, b_op = OP_IDLE;
    logic [AW-1:0]    m1_a = '0, m2_a = '0, b_base = '0;
    logic [LANES-1:0] m1_m = '0, m2_m = '0;
    logic [1:0]       b_cnt = '0;
    logic             exp_vld = 1'b0;
    logic [W-1:0]     exp_data = '0;
    logic [W-1:0]     dq1 = '0, dq2 = '0, pend = '0;

    function automatic logic [1:0] want_off(input logic [1:0] s, input logic [1:0] n,
                                            input logic lin);
        logic [2:0] sum;
        sum = {1'b0, s} + {1'b0, n};
        if (lin) return sum[1:0];
        return {s[1] ^ n[1], s[0] ^ n[0]};
    endfunction

    function automatic logic [W-1:0] pat(input int i);
        logic [8:0] v;
        v = 9'(i * 29 + 7);
        return {v, ~v, v ^ 9'h0AA, 9'(i)};
    endfunction

    task automatic check_now();
        logic       want;
        logic [W:0] got;
        logic [W:0] exp;
        want = exp_vld && !oe_n && !sleep;
        got  = {dout_oe, dout};
        exp  = {want, want ? exp_data : {W{1'b0}}};
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got oe=%0b data=%h, expected oe=%0b data=%h",
                     cur_req, got[W], got[W-1:0], exp[W], exp[W-1:0]);
        end
    endtask

    task automatic model_edge();
        if (rst) begin
            m1_op = OP_IDLE; m2_op = OP_IDLE; b_op = OP_IDLE; exp_vld = 1'b0;
            b_base = '0; b_cnt = '0;
        end else if (!cke_n) begin
            if (m2_op == OP_WRITE) begin
                for (int l = 0; l < LANES; l++) begin
                    if (m2_m[l]) ref_mem[m2_a][l*LANE_W +: LANE_W] = din[l*LANE_W +: LANE_W];
                end
            end
            exp_vld = (m2_op == OP_READ);
            if (exp_vld) exp_data = ref_mem[m2_a];
            m2_op = m1_op; m2_a = m1_a; m2_m = m1_m;
            m1_m = ~bw_n;
            if (!advance) begin
                if (!ce_a_n && !ce_b_n && ce_c && !sleep)
                    m1_op = we_n ? OP_READ : OP_WRITE;
                else
                    m1_op = OP_IDLE;
                b_op = m1_op; b_base = addr; b_cnt = '0; m1_a = addr;
            end else begin
                b_cnt = b_cnt + 2'd1;
                if (sleep) b_op = OP_IDLE;
                m1_op = b_op;
                m1_a  = {b_base[AW-1:2], want_off(b_base[1:0], b_cnt, order_lin)};
            end
            dq2 = dq1; dq1 = pend;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        #1;
        check_now();
    endtask

    task automatic put_ce(input logic adv, input logic wen, input logic ca_n,
                          input logic cb_n, input logic cc, input logic [LANES-1:0] bwn,
                          input logic [AW-1:0] a, input logic [W-1:0] d);
        cke_n = 1'b0; advance = adv; we_n = wen;
        ce_a_n = ca_n; ce_b_n = cb_n; ce_c = cc;
        bw_n = bwn; addr = a; din = dq2; pend = d;
        tick();
    endtask

    task automatic rd(input logic [AW-1:0] a);
        put_ce(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, '1, a, '0);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d,
                      input logic [LANES-1:0] bwn);
        put_ce(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, bwn, a, d);
    endtask

    // Advance with chip enables deasserted to show they are ignored.
    task automatic adv(input logic [W-1:0] d);
        put_ce(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'b0000, '0, d);
    endtask

    task automatic nop();
        put_ce(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, '1, '0, '0);
    endtask

    task automatic freeze(input int n);
        for (int i = 0; i < n; i++) begin
            cke_n = 1'b1; advance = 1'b0; we_n = 1'b0;
            ce_a_n = 1'b0; ce_b_n = 1'b0; ce_c = 1'b1;
            bw_n = '0; addr = AW'(i + 40); din = ~dq2;
            tick();
        end
    endtask

    task automatic summary_and_end();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got hung run, expected completion");
        summary_and_end();
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd7319);

        // R12: reset state
        cur_req = "R12";
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;

        // R2: fill every word
        cur_req = "R2";
        for (int i = 0; i < DEPTH; i++) wr(AW'(i), pat(i), 4'b0000);
        nop(); nop();

        // R1: single reads
        cur_req = "R1";
        rd(6'd3); rd(6'd40); rd(6'd63); nop(); nop(); nop();

        // R3: partial lane writes
        cur_req = "R3";
        wr(6'd5, 36'h123456789, 4'b0101);
        wr(6'd6, 36'hFEDCBA987, 4'b1110);
        nop(); rd(6'd5); rd(6'd6); nop(); nop();

        // R4: write then read same word, read then write same word
        cur_req = "R4";
        wr(6'd9, 36'hA5A5A5A5A, 4'b0000); rd(6'd9);
        rd(6'd10); wr(6'd10, 36'h0F0F0F0F0, 4'b0000); rd(6'd10);
        nop(); nop(); nop();

        // R5: linear bursts
        cur_req = "R5";
        order_lin = 1'b1;
        wr(6'd13, 36'h111111111, 4'b0000);
        adv(36'h222222222); adv(36'h333333333); adv(36'h444444444);
        nop(); rd(6'd12); rd(6'd13); rd(6'd14); rd(6'd15);
        rd(6'd14); adv('0); adv('0); adv('0); adv('0); nop(); nop();

        // R6: interleaved bursts
        cur_req = "R6";
        order_lin = 1'b0;
        wr(6'd18, 36'h555555555, 4'b0000);
        adv(36'h666666666); adv(36'h777777777); adv(36'h888888888);
        nop(); rd(6'd16); rd(6'd17); rd(6'd18); rd(6'd19);
        rd(6'd23); adv('0); adv('0); adv('0); nop(); nop();

        // R7: advance after a deselected load stays deselected
        cur_req = "R7";
        order_lin = 1'b1;
        put_ce(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'b0000, 6'd32, '0);
        put_ce(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0000, 6'd0, 36'hDEADBEEF1);
        put_ce(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0000, 6'd0, 36'hDEADBEEF2);
        nop(); rd(6'd33); rd(6'd34); rd(6'd33); adv('0); nop(); nop();

        // R8: each single disabled enable makes a deselect
        cur_req = "R8";
        put_ce(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'b0000, 6'd44, 36'h1);
        put_ce(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'b0000, 6'd44, 36'h2);
        put_ce(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000, 6'd44, 36'h3);
        put_ce(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, '1, 6'd45, '0);
        nop(); rd(6'd44); nop(); nop();

        // R9: clock enable stalls
        cur_req = "R9";
        rd(6'd11); nop(); freeze(3); nop(); freeze(2); nop(); nop();

        // R10: output enable acts without a clock edge
        cur_req = "R10";
        rd(6'd7); nop(); nop();
        oe_n = 1'b1; #0.5; check_now();
        oe_n = 1'b0; #0.5; check_now();
        nop();

        // R11: sleep disables outputs at once and blocks captures
        cur_req = "R11";
        rd(6'd8); nop(); nop();
        sleep = 1'b1; #0.5; check_now();
        wr(6'd8, 36'hBADBADBAD, 4'b0000);
        adv(36'hBADBADBAD); nop(); nop();
        sleep = 1'b0;
        rd(6'd8); rd(6'd9); nop(); nop();

        // R12: reset mid-flight drops a pending read
        cur_req = "R12";
        rd(6'd3);
        rst = 1'b1; tick(); rst = 1'b0;
        nop(); nop();

        // R4: constrained random mix
        cur_req = "R4";
        for (int k = 0; k < 4000; k++) begin
            int unsigned r;
            if (k % 500 == 0) order_lin = 1'($urandom % 2);
            r = $urandom % 12;
            cke_n   = (($urandom % 10) == 0);
            advance = (($urandom % 10) < 3);
            we_n    = 1'($urandom % 2);
            ce_a_n  = (r == 9);
            ce_b_n  = (r == 10);
            ce_c    = (r != 11);
            bw_n    = LANES'($urandom);
            addr    = AW'($urandom);
            oe_n    = (($urandom % 8) == 0);
            sleep   = (($urandom % 40) == 0);
            din     = dq2;
            pend    = W'({$urandom, $urandom});
            tick();
        end
        oe_n = 1'b0; sleep = 1'b0;
        nop(); nop(); nop();

        summary_and_end();
    end

endmodule